// File: doc/BRIEF.md
# LED Driver Power Mode Controller

This block is the operating-mode state machine of a multi-channel LED driver. It follows the enable pin, the chip-enable and power-save configuration bits, an "all channel outputs idle" indication, the undervoltage and over-temperature detector results, a strobe for each completed bus command, and the external active-low reset pin. From these it selects one of six modes and derives an analog power-down control, an output-drive enable, a one-cycle interface reset and a register reset.

All time windows are measured in ticks, where one tick is `TICK_DIV` system clock cycles (1 ms at the default 50 MHz divider). Each window has its own prescaler, which restarts whenever the condition being timed drops. A window of N ticks therefore closes after exactly N x `TICK_DIV` consecutive cycles of the condition. All inputs are assumed to be synchronous to `clk` already.

Mode codes are: off = 0, init = 1, standby = 2, run = 3, save = 4, hot = 5. `analog_pd` is low only in run and hot. `drive_en` is high only in run.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the block is in mode 0 (off) with `analog_pd`=1, `drive_en`=0, `if_reset`=0 and `reg_reset`=0.
- R2: In mode 0, `en_pin`=1 moves the block to mode 1 (init) on the next edge. `reg_reset` is high for as long as the mode is 1. With `uvlo` low and `en_pin` high, mode 1 lasts one cycle and is followed by mode 2 (standby).
- R3: In mode 2, `chip_en`=1 gives mode 3 (run) on the next edge, with `analog_pd`=0 and `drive_en`=1. In mode 3, `chip_en`=0 gives mode 2 on the next edge.
- R4: In mode 3, with `psave_en`=1 and `all_idle`=1 held, mode 4 (save, `analog_pd`=1, `drive_en`=0) follows on the edge after IDLE_MS x TICK_DIV consecutive qualifying cycles. Any cycle that breaks the condition restarts the count. With `psave_en`=0 the block never enters mode 4.
- R5: In mode 4, `bus_cmd`=1 returns the block to mode 3 on the next edge.
- R6: From any mode other than 0, `en_pin` held low for ENOFF_MS x TICK_DIV consecutive cycles gives mode 0 on the following edge. A single high cycle restarts the count. Mode 0 is kept while `en_pin` stays low.
- R7: From any mode other than 0, `uvlo`=1 gives mode 1 on the next edge, and mode 1 is held while `uvlo` stays high. Once `uvlo` clears, the block passes through mode 2.
- R8: In modes 2, 3 or 4, `otp`=1 gives mode 5 (hot) with `drive_en`=0 and `analog_pd`=0, held while `otp` stays high. When `otp` clears, the block goes to mode 3 if `chip_en`=1 and to mode 2 otherwise.
- R9: A low pulse on `rstn_pin` lasting L cycles counts n = floor(L / TICK_DIV) ticks. A pulse with n < RST_MIN_MS produces neither reset output.
- R10: A pulse with RST_MIN_MS <= n < RST_MAX_MS produces exactly one `if_reset` cycle, on the edge after `rstn_pin` returns high. It leaves `reg_reset` and the mode unchanged.
- R11: A pulse with n >= RST_MAX_MS produces exactly one `reg_reset` cycle, on the edge after release. It leaves `if_reset` and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low supply-good / power-on reset |
| en_pin | input | 1 | Device enable pin level |
| chip_en | input | 1 | Chip-enable configuration bit |
| psave_en | input | 1 | Automatic power-save enable bit |
| all_idle | input | 1 | High when every channel output is off |
| uvlo | input | 1 | Undervoltage-lockout detector result |
| otp | input | 1 | Over-temperature shutdown detector result |
| bus_cmd | input | 1 | One-cycle strobe per received bus command |
| rstn_pin | input | 1 | Active-low external reset pin level |
| mode | output | 3 | Current mode code (0..5) |
| analog_pd | output | 1 | Analog power-down control |
| drive_en | output | 1 | Channel output drive enable |
| if_reset | output | 1 | One-cycle bus interface reset |
| reg_reset | output | 1 | Register file reset |

## Verification
The idle timer is driven three ways. The first holds the idle condition with power-save disabled, which separates the gating from the timing. The second breaks the condition for one cycle near the end of the window, which shows whether the count restarts. The third runs one unbroken window, checked on both sides of its exact closing edge. The enable-low timer is also interrupted once and then timed exactly.

Reset-pin pulses of 3, 4, 79 and 80 cycles (tick of 4 cycles) fall on either side of each classification threshold. Each pulse is followed by a check one cycle later, which shows the reset output is a single cycle. Over-temperature is raised from both standby and run, which tells apart the two release targets.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_INIT = 3'd1,
    MODE_STBY = 3'd2,
    MODE_RUN  = 3'd3,
    MODE_SAVE = 3'd4,
    MODE_HOT  = 3'd5
  } pmcMode_e;

  // control -> datapath: which windows are currently being timed
  typedef struct packed {
    logic idleRun;
    logic enLowRun;
  } pmcStrobe_t;

  // datapath -> control: closed windows and classified reset pulses
  typedef struct packed {
    logic idleDone;
    logic enLowDone;
    logic ifRstEvt;
    logic regRstEvt;
  } pmcEvent_t;

endpackage

// File: rtl/pmc_span_timer.sv
module pmc_span_timer #(
  parameter int TICK_DIV = 50000,
  parameter int LIMIT    = 30
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  output logic [$clog2(LIMIT+1)-1:0]   ticks
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = $clog2(LIMIT + 1);

  logic [PW-1:0] preQ;

  // prescaler restarts with the window, so N ticks == N*TICK_DIV cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preQ  <= '0;
      ticks <= '0;
    end else if (!run) begin
      preQ  <= '0;
      ticks <= '0;
    end else if (preQ == PW'(TICK_DIV - 1)) begin
      preQ <= '0;
      if (ticks != CW'(LIMIT)) ticks <= ticks + 1'b1;
    end else begin
      preQ <= preQ + 1'b1;
    end
  end

  assert_ticks_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (ticks >= $past(ticks)));

  assert_ticks_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ticks == '0));

endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int IDLE_MS    = 30,
  parameter int ENOFF_MS   = 25,
  parameter int RST_MIN_MS = 1,
  parameter int RST_MAX_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pmcStrobe_t strobe,
  input  logic       rstnPin,
  output pmcEvent_t  evt
);
  localparam int ICW = $clog2(IDLE_MS + 1);
  localparam int ECW = $clog2(ENOFF_MS + 1);
  localparam int PCW = $clog2(RST_MAX_MS + 1);

  logic [ICW-1:0] idleTicks;
  logic [ECW-1:0] enLowTicks;
  logic [PCW-1:0] pinTicks;
  logic           rstnPrev;
  logic           pinRelease;

  pmc_span_timer #(.TICK_DIV(TICK_DIV), .LIMIT(IDLE_MS)) u_idle (
    .clk(clk), .rst_n(rst_n), .run(strobe.idleRun), .ticks(idleTicks));

  pmc_span_timer #(.TICK_DIV(TICK_DIV), .LIMIT(ENOFF_MS)) u_enLow (
    .clk(clk), .rst_n(rst_n), .run(strobe.enLowRun), .ticks(enLowTicks));

  pmc_span_timer #(.TICK_DIV(TICK_DIV), .LIMIT(RST_MAX_MS)) u_pin (
    .clk(clk), .rst_n(rst_n), .run(!rstnPin), .ticks(pinTicks));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rstnPrev <= 1'b1;
    else        rstnPrev <= rstnPin;
  end

  // pin timer still holds the pulse width in the first high cycle
  assign pinRelease = rstnPin && !rstnPrev;

  always_comb begin
    evt.idleDone  = (idleTicks  == ICW'(IDLE_MS));
    evt.enLowDone = (enLowTicks == ECW'(ENOFF_MS));
    evt.ifRstEvt  = pinRelease && (pinTicks >= PCW'(RST_MIN_MS))
                               && (pinTicks <  PCW'(RST_MAX_MS));
    evt.regRstEvt = pinRelease && (pinTicks == PCW'(RST_MAX_MS));
  end

  assert_release_follows_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.ifRstEvt || evt.regRstEvt) |-> $past(!rstnPin));

  assert_idle_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.idleDone |-> $past(strobe.idleRun));

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enPin,
  input  logic       chipEn,
  input  logic       psaveEn,
  input  logic       allIdle,
  input  logic       uvlo,
  input  logic       otp,
  input  logic       busCmd,
  input  pmcEvent_t  evt,
  output pmcStrobe_t strobe,
  output pmcMode_e   stateQ,
  output logic       ifPulse,
  output logic       regPulse
);
  pmcMode_e stateD;

  assign strobe.idleRun  = (stateQ == MODE_RUN) && psaveEn && allIdle;
  assign strobe.enLowRun = !enPin && (stateQ != MODE_OFF);

  always_comb begin
    stateD = stateQ;
    if (stateQ == MODE_OFF) begin
      if (enPin) stateD = MODE_INIT;
    end else if (evt.enLowDone) begin
      stateD = MODE_OFF;
    end else if (uvlo) begin
      stateD = MODE_INIT;
    end else begin
      case (stateQ)
        MODE_INIT: if (enPin) stateD = MODE_STBY;
        MODE_STBY: begin
          if (otp)         stateD = MODE_HOT;
          else if (chipEn) stateD = MODE_RUN;
        end
        MODE_RUN: begin
          if (otp)               stateD = MODE_HOT;
          else if (!chipEn)      stateD = MODE_STBY;
          else if (evt.idleDone) stateD = MODE_SAVE;
        end
        MODE_SAVE: begin
          if (otp)         stateD = MODE_HOT;
          else if (busCmd) stateD = MODE_RUN;
        end
        MODE_HOT: if (!otp) stateD = chipEn ? MODE_RUN : MODE_STBY;
        default: stateD = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= MODE_OFF;
      ifPulse  <= 1'b0;
      regPulse <= 1'b0;
    end else begin
      stateQ   <= stateD;
      ifPulse  <= evt.ifRstEvt;
      regPulse <= evt.regRstEvt;
    end
  end

  assert_off_exits_to_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == MODE_OFF) |=> (stateQ == MODE_OFF || stateQ == MODE_INIT));

  assert_save_only_from_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ != MODE_SAVE && stateQ != MODE_RUN) |=> (stateQ != MODE_SAVE));

  assert_hot_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == MODE_HOT && otp && enPin && !uvlo) |=> (stateQ == MODE_HOT));

  assert_uvlo_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo && enPin && stateQ != MODE_OFF) |=> (stateQ == MODE_INIT));

  assert_pulses_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ifPulse, regPulse}));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int IDLE_MS    = 30,
  parameter int ENOFF_MS   = 25,
  parameter int RST_MIN_MS = 1,
  parameter int RST_MAX_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       chip_en,
  input  logic       psave_en,
  input  logic       all_idle,
  input  logic       uvlo,
  input  logic       otp,
  input  logic       bus_cmd,
  input  logic       rstn_pin,
  output logic [2:0] mode,
  output logic       analog_pd,
  output logic       drive_en,
  output logic       if_reset,
  output logic       reg_reset
);
  pmcStrobe_t strobe;
  pmcEvent_t  evt;
  pmcMode_e   stateQ;
  logic       ifPulse;
  logic       regPulse;

  pmc_datapath #(
    .TICK_DIV(TICK_DIV), .IDLE_MS(IDLE_MS), .ENOFF_MS(ENOFF_MS),
    .RST_MIN_MS(RST_MIN_MS), .RST_MAX_MS(RST_MAX_MS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rstnPin(rstn_pin), .evt(evt));

  pmc_fsm u_ctl (
    .clk(clk), .rst_n(rst_n), .enPin(en_pin), .chipEn(chip_en),
    .psaveEn(psave_en), .allIdle(all_idle), .uvlo(uvlo), .otp(otp),
    .busCmd(bus_cmd), .evt(evt), .strobe(strobe), .stateQ(stateQ),
    .ifPulse(ifPulse), .regPulse(regPulse));

  assign mode      = stateQ;
  assign analog_pd = !(stateQ == MODE_RUN || stateQ == MODE_HOT);
  assign drive_en  = (stateQ == MODE_RUN);
  assign if_reset  = ifPulse;
  assign reg_reset = regPulse || (stateQ == MODE_INIT);

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam int TD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, chip_en = 1'b0, psave_en = 1'b0, all_idle = 1'b0;
  logic uvlo = 1'b0, otp = 1'b0, bus_cmd = 1'b0, rstn_pin = 1'b1;
  logic [2:0] mode;
  logic analog_pd, drive_en, if_reset, reg_reset;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.TICK_DIV(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .chip_en(chip_en),
    .psave_en(psave_en), .all_idle(all_idle), .uvlo(uvlo), .otp(otp),
    .bus_cmd(bus_cmd), .rstn_pin(rstn_pin), .mode(mode),
    .analog_pd(analog_pd), .drive_en(drive_en), .if_reset(if_reset),
    .reg_reset(reg_reset));

  typedef struct {
    logic [2:0] m;
    logic ifL;
    logic regL;
    int   ifN;
    int   regN;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  int expIf = 0, expReg = 0;
  int seenIf = 0, seenReg = 0;
  logic prevIf = 1'b0, prevReg = 1'b0;
  bit finished = 1'b0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input logic [2:0] m, input logic ifL,
                            input logic regL, input string tag);
    item_t it;
    it.m = m; it.ifL = ifL; it.regL = regL;
    it.ifN = expIf; it.regN = expReg; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: count reset pulses, then score every pending expectation
  always @(negedge clk) begin
    if (if_reset && !prevIf)   seenIf++;
    if (reg_reset && !prevReg) seenReg++;
    prevIf = if_reset;
    prevReg = reg_reset;
    while (q.size() > 0) begin
      item_t it;
      logic expPd, expDrv;
      it = q.pop_front();
      expPd  = !(it.m == 3'd3 || it.m == 3'd5);
      expDrv = (it.m == 3'd3);
      checks++;
      if (mode !== it.m || analog_pd !== expPd || drive_en !== expDrv ||
          if_reset !== it.ifL || reg_reset !== it.regL ||
          seenIf != it.ifN || seenReg != it.regN) begin
        failures++;
        $display("FAIL %s: mode/pd/drv/if/reg/nIf/nReg actual %0d/%0b/%0b/%0b/%0b/%0d/%0d expected %0d/%0b/%0b/%0b/%0b/%0d/%0d",
                 it.tag, mode, analog_pd, drive_en, if_reset, reg_reset, seenIf, seenReg,
                 it.m, expPd, expDrv, it.ifL, it.regL, it.ifN, it.regN);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1);
    expect_now(3'd0, 0, 0, "R1 reset state");

    en_pin = 1'b1;
    step(1); expReg++;
    expect_now(3'd1, 0, 1, "R2 init with register reset");
    step(1);
    expect_now(3'd2, 0, 0, "R2 standby after init");

    chip_en = 1'b1;
    step(1);
    expect_now(3'd3, 0, 0, "R3 run");

    all_idle = 1'b1;
    step(150);
    expect_now(3'd3, 0, 0, "R4 no save while disabled");

    psave_en = 1'b1;
    step(100);
    all_idle = 1'b0;
    step(1);
    all_idle = 1'b1;
    step(110);
    expect_now(3'd3, 0, 0, "R4 window restarted");
    step(10);
    expect_now(3'd3, 0, 0, "R4 last idle cycle");
    step(1);
    expect_now(3'd4, 0, 0, "R4 save entered");

    bus_cmd = 1'b1; all_idle = 1'b0;
    step(1);
    bus_cmd = 1'b0;
    expect_now(3'd3, 0, 0, "R5 wake on bus command");

    chip_en = 1'b0;
    step(1);
    expect_now(3'd2, 0, 0, "R3 back to standby");
    otp = 1'b1;
    step(1);
    expect_now(3'd5, 0, 0, "R8 hot from standby");
    otp = 1'b0;
    step(1);
    expect_now(3'd2, 0, 0, "R8 release to standby");
    chip_en = 1'b1;
    step(1);
    expect_now(3'd3, 0, 0, "R3 run again");

    otp = 1'b1;
    step(1);
    expect_now(3'd5, 0, 0, "R8 hot from run");
    step(10);
    expect_now(3'd5, 0, 0, "R8 hot held");
    otp = 1'b0;
    step(1);
    expect_now(3'd3, 0, 0, "R8 release to run");

    rstn_pin = 1'b0; step(3); rstn_pin = 1'b1;
    step(3);
    expect_now(3'd3, 0, 0, "R9 glitch ignored");

    rstn_pin = 1'b0; step(4); rstn_pin = 1'b1;
    step(1); expIf++;
    expect_now(3'd3, 1, 0, "R10 shortest interface reset");
    step(1);
    expect_now(3'd3, 0, 0, "R10 single cycle");

    rstn_pin = 1'b0; step(79); rstn_pin = 1'b1;
    step(1); expIf++;
    expect_now(3'd3, 1, 0, "R10 longest interface reset");
    step(1);

    rstn_pin = 1'b0; step(80); rstn_pin = 1'b1;
    step(1); expReg++;
    expect_now(3'd3, 0, 1, "R11 register reset");
    step(1);
    expect_now(3'd3, 0, 0, "R11 single cycle");

    uvlo = 1'b1;
    step(1); expReg++;
    expect_now(3'd1, 0, 1, "R7 undervoltage to init");
    step(3);
    expect_now(3'd1, 0, 1, "R7 init held");
    uvlo = 1'b0;
    step(1);
    expect_now(3'd2, 0, 0, "R7 through standby");
    step(1);
    expect_now(3'd3, 0, 0, "R7 back to run");

    en_pin = 1'b0; step(50); en_pin = 1'b1; step(1); en_pin = 1'b0;
    step(100);
    expect_now(3'd3, 0, 0, "R6 last enable-low cycle");
    step(1);
    expect_now(3'd0, 0, 0, "R6 shutdown");
    step(5);
    expect_now(3'd0, 0, 0, "R6 shutdown kept");

    en_pin = 1'b1;
    step(1); expReg++;
    expect_now(3'd1, 0, 1, "R2 re-init");
    step(1);
    expect_now(3'd2, 0, 0, "R2 standby after re-init");
    step(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule